// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block holds the event and interrupt-summary word of a descriptor-based DMA controller. The transmit and receive engines each send one-cycle pulses when something happens: a frame is done, no buffer is free, or the engine has stopped. Each pulse sets its own sticky bit. A host on a simple register bus reads the word at byte offset 0x14. It clears bits by writing ones to them.

A companion enable word at offset 0x1C uses the same bit positions. It selects which sticky events feed two summary bits. The "normal" summary covers completions and transmit starvation. The "abnormal" summary covers stops and receive starvation. Two further enable bits decide whether each summary drives the single interrupt line.

The status word also carries the live 3-bit process-state codes of both engines. These codes are read-only and never cause an interrupt. Register reads are combinational from the address. Writes take effect on the clock edge at which the write strobe is high.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, the words at 0x14 and 0x1C read back with all event, summary and enable bits at 0, and irq_o is 0.
- R2: A one-cycle pulse sets a status bit at 0x14, and the bit is visible on the read port in the cycle after the pulse. The positions are: tx_done_i → bit 0, tx_stop_i → bit 1, tx_nobuf_i → bit 2, rx_done_i → bit 6, rx_nobuf_i → bit 7, rx_stop_i → bit 8.
- R3: A set event bit stays set until the host writes 1 to that position at 0x14. Writing 0 to a position leaves that bit unchanged.
- R4: If a pulse and a write-one-to-clear reach the same bit in the same cycle, the bit stays set.
- R5: Bit 16 of 0x14 (normal summary) is the OR of status bits 0, 2 and 6, each ANDed with the enable bit at the same position in 0x1C. Bit 16 is derived from those bits, so writing to it has no separate effect.
- R6: Bit 15 of 0x14 (abnormal summary) is the OR of status bits 1, 7 and 8, each ANDed with its enable bit at 0x1C. Bit 15 is also derived, so writing to it has no separate effect.
- R7: irq_o equals (bit16 AND enable bit 16) OR (bit15 AND enable bit 15). It follows a change of that value one clock later.
- R8: Bits 22:20 of 0x14 show tx_state_i and bits 19:17 show rx_state_i, both live. Writes to these bits are ignored, and the state codes never assert irq_o.
- R9: Bits 31:23 and bits 14:9 and 5:3 of 0x14 read 0, and writes to them are ignored.
- R10: 0x1C is writable at bits 0, 1, 2, 6, 7, 8, 15 and 16 and reads back what was written there. All its other bits read 0.
- R11: Any other address reads 0, and writing it changes neither word nor irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte address |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| tx_done_i | input | 1 | Transmit completion pulse |
| tx_stop_i | input | 1 | Transmit process stopped pulse |
| tx_nobuf_i | input | 1 | Transmit descriptor unavailable pulse |
| rx_done_i | input | 1 | Receive completion pulse |
| rx_nobuf_i | input | 1 | Receive buffer unavailable pulse |
| rx_stop_i | input | 1 | Receive process stopped pulse |
| tx_state_i | input | 3 | Transmit process state code |
| rx_state_i | input | 3 | Receive process state code |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench tries every combination of the six events against sixteen enable patterns. Each pattern includes junk in the unwritable bits. Any event assigned to the wrong summary group, or a mask that is ignored, shows up as a wrong bit 15 or 16, or as a wrong irq_o. A same-cycle pulse and clear catches a design that lets the clear win and so loses an event. Writes of zero, partial clears, writes to the state and reserved fields, and writes to an unused address catch designs that clear or store too much. A check of irq_o exactly one cycle after each event catches a line that is combinational or late by a cycle.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int STATE_W = 3;
  localparam int N_EVT   = 6;

  localparam logic [ADDR_W-1:0] STATUS_OFS = 8'h14;
  localparam logic [ADDR_W-1:0] ENABLE_OFS = 8'h1C;

  localparam int NIS_POS = 16;
  localparam int AIS_POS = 15;
  localparam int TXS_LSB = 20;
  localparam int RXS_LSB = TXS_LSB - STATE_W;

  // event index order: tx_done, tx_stop, tx_nobuf, rx_done, rx_nobuf, rx_stop
  localparam logic [N_EVT-1:0] NORM_GRP = 6'b001101;
  localparam logic [N_EVT-1:0] ABN_GRP  = 6'b110010;

  function automatic int evt_pos(input int idx);
    case (idx)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 6;
      4: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] spread(input logic [N_EVT-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < N_EVT; i++) w[evt_pos(i)] = v[i];
    return w;
  endfunction

  function automatic logic [N_EVT-1:0] gather(input logic [DATA_W-1:0] w);
    logic [N_EVT-1:0] v;
    for (int i = 0; i < N_EVT; i++) v[i] = w[evt_pos(i)];
    return v;
  endfunction
endpackage

// File: rtl/dma_irq_events.sv
module dma_irq_events #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       sts_o[g] <= 1'b0;
      else if (set_i[g]) sts_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) sts_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_enable.sv
module dma_irq_enable
  import dma_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_EVT-1:0]  evt_en_o,
  output logic              nis_en_o,
  output logic              ais_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_en_o <= '0;
      nis_en_o <= 1'b0;
      ais_en_o <= 1'b0;
    end else if (we_i) begin
      evt_en_o <= gather(wdata_i);
      nis_en_o <= wdata_i[NIS_POS];
      ais_en_o <= wdata_i[AIS_POS];
    end
  end
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] sts_i,
  input  logic [N_EVT-1:0] evt_en_i,
  input  logic             nis_en_i,
  input  logic             ais_en_i,
  output logic             nis_o,
  output logic             ais_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] live;
  logic             irq_d;

  assign live  = sts_i & evt_en_i;
  assign nis_o = |(live & NORM_GRP);
  assign ais_o = |(live & ABN_GRP);
  assign irq_d = (nis_o & nis_en_i) | (ais_o & ais_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_we_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic               tx_done_i,
  input  logic               tx_stop_i,
  input  logic               tx_nobuf_i,
  input  logic               rx_done_i,
  input  logic               rx_nobuf_i,
  input  logic               rx_stop_i,
  input  logic [STATE_W-1:0] tx_state_i,
  input  logic [STATE_W-1:0] rx_state_i,
  output logic               irq_o
);
  logic [N_EVT-1:0] evt_vec, sts_q, sts_clr, evt_en;
  logic             nis_en, ais_en, nis, ais;
  logic             sts_wr, en_wr;

  assign evt_vec = {rx_stop_i, rx_nobuf_i, rx_done_i, tx_nobuf_i, tx_stop_i, tx_done_i};
  assign sts_wr  = reg_we_i && (reg_addr_i == STATUS_OFS);
  assign en_wr   = reg_we_i && (reg_addr_i == ENABLE_OFS);
  assign sts_clr = sts_wr ? gather(reg_wdata_i) : '0;

  dma_irq_events #(.N(N_EVT)) u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_vec),
    .clr_i  (sts_clr),
    .sts_o  (sts_q)
  );

  dma_irq_enable u_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (en_wr),
    .wdata_i  (reg_wdata_i),
    .evt_en_o (evt_en),
    .nis_en_o (nis_en),
    .ais_en_o (ais_en)
  );

  dma_irq_summary u_summary (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sts_i    (sts_q),
    .evt_en_i (evt_en),
    .nis_en_i (nis_en),
    .ais_en_i (ais_en),
    .nis_o    (nis),
    .ais_o    (ais),
    .irq_o    (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      STATUS_OFS: begin
        reg_rdata_o                     = spread(sts_q);
        reg_rdata_o[NIS_POS]            = nis;
        reg_rdata_o[AIS_POS]            = ais;
        reg_rdata_o[TXS_LSB +: STATE_W] = tx_state_i;
        reg_rdata_o[RXS_LSB +: STATE_W] = rx_state_i;
      end
      ENABLE_OFS: begin
        reg_rdata_o          = spread(evt_en);
        reg_rdata_o[NIS_POS] = nis_en;
        reg_rdata_o[AIS_POS] = ais_en;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
  import dma_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_EVT-1:0]   evt_i,
  input logic [N_EVT-1:0]   sts_i,
  input logic [N_EVT-1:0]   clr_i,
  input logic               irq_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  rdata_i,
  input logic [STATE_W-1:0] txs_i,
  input logic [STATE_W-1:0] rxs_i
);
  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sts_i & $past(evt_i)) == $past(evt_i)));

  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((sts_i & $past(sts_i)) == $past(sts_i)));

  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((evt_i & clr_i) != '0) |=> ((sts_i & $past(evt_i & clr_i)) == $past(evt_i & clr_i)));

  a_r7_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> ($past(sts_i) != '0));

  a_r8_state_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STATUS_OFS) |-> (rdata_i[TXS_LSB +: STATE_W] == txs_i &&
                                rdata_i[RXS_LSB +: STATE_W] == rxs_i));

  a_r9_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_i[DATA_W-1:TXS_LSB+STATE_W] == '0);
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .evt_i   (evt_vec),
  .sts_i   (sts_q),
  .clr_i   (sts_clr),
  .irq_i   (irq_o),
  .addr_i  (reg_addr_i),
  .rdata_i (reg_rdata_o),
  .txs_i   (tx_state_i),
  .rxs_i   (rx_state_i)
);

// File: tb/dma_irq_status_tb.sv
module dma_irq_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  ev = '0;
  logic [2:0]  txs = '0, rxs = '0;
  logic        irq;
  int          checks = 0, errors = 0, cycles = 0;

  localparam logic [7:0] A_STS = 8'h14, A_EN = 8'h1C;

  always #4 clk = ~clk;

  dma_irq_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_done_i(ev[0]), .tx_stop_i(ev[1]), .tx_nobuf_i(ev[2]),
    .rx_done_i(ev[3]), .rx_nobuf_i(ev[4]), .rx_stop_i(ev[5]),
    .tx_state_i(txs), .rx_state_i(rxs), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] evmap(input logic [5:0] e);
    return {23'b0, e[5], e[4], e[3], 3'b000, e[2], e[1], e[0]};
  endfunction

  function automatic logic [31:0] exp_sts(input logic [5:0] e, input logic [31:0] en,
                                          input logic [2:0] t, input logic [2:0] r);
    logic [31:0] s;
    s = evmap(e);
    s[16] = |(s & en & 32'h0000_0045);
    s[15] = |(s & en & 32'h0000_0182);
    s[22:20] = t;
    s[19:17] = r;
    return s;
  endfunction

  function automatic logic exp_irq(input logic [5:0] e, input logic [31:0] en);
    logic [31:0] s;
    s = evmap(e);
    return (|(s & en & 32'h0000_0045) & en[16]) | (|(s & en & 32'h0000_0182) & en[15]);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [5:0] e);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, en, en_eff;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(A_STS, v); chk("R1 status", v & 32'h0001_81C7, 32'h0);
    rd(A_EN, v);  chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // sweep: every event set against 16 enable patterns
    for (int m = 0; m < 16; m++) begin
      en = 32'hFE00_7E38;
      if (m[0]) en |= 32'h0000_0007;
      if (m[1]) en |= 32'h0000_01C0;
      if (m[2]) en |= 32'h0001_0000;
      if (m[3]) en |= 32'h0000_8000;
      en_eff = en & 32'h0001_81C7;
      for (int e = 0; e < 64; e++) begin
        txs = e[2:0]; rxs = e[5:3];
        wr(A_EN, en);
        wr(A_STS, 32'hFFFF_FFFF);
        pulse(e[5:0]);
        chk("R7 latency", {31'b0, irq}, 32'h0);
        rd(A_STS, v); chk("R2 R5 R6 R8 R9 status", v, exp_sts(e[5:0], en_eff, txs, rxs));
        rd(A_EN, v);  chk("R10 enable readback", v, en_eff);
        @(negedge clk);
        chk("R7 irq", {31'b0, irq}, {31'b0, exp_irq(e[5:0], en_eff)});
      end
    end

    // R3 write zero and partial clear
    txs = 3'd0; rxs = 3'd0;
    wr(A_EN, 32'h0001_81C7);
    wr(A_STS, 32'hFFFF_FFFF);
    pulse(6'h3F);
    wr(A_STS, 32'h0);
    rd(A_STS, v); chk("R3 write zero keeps", v, exp_sts(6'h3F, 32'h0001_81C7, 3'd0, 3'd0));
    wr(A_STS, 32'h0000_0082);
    rd(A_STS, v); chk("R3 partial clear", v, exp_sts(6'h2D, 32'h0001_81C7, 3'd0, 3'd0));

    // R6 abnormal summary drops when its sources go; normal stays
    rd(A_STS, v); chk("R6 abnormal from bit8", {31'b0, v[15]}, 32'h1);
    wr(A_STS, 32'h0000_0100);
    rd(A_STS, v); chk("R6 abnormal cleared", {31'b0, v[15]}, 32'h0);
    chk("R5 normal kept", {31'b0, v[16]}, 32'h1);

    // R5 writing summary bits has no separate effect
    wr(A_STS, 32'h0001_8000);
    rd(A_STS, v); chk("R5 summary write", v, exp_sts(6'h0D, 32'h0001_81C7, 3'd0, 3'd0));

    // R4 set and clear in same cycle
    wr(A_STS, 32'hFFFF_FFFF);
    ev = 6'h01; addr = A_STS; wdata = 32'h0000_0001; we = 1'b1;
    @(negedge clk);
    we = 1'b0; ev = '0;
    rd(A_STS, v); chk("R4 set wins", v[8:0], 9'h001);

    // R11 unused address
    wr(8'h18, 32'hFFFF_FFFF);
    rd(A_STS, v); chk("R11 status untouched", v[8:0], 9'h001);
    rd(A_EN, v);  chk("R11 enable untouched", v, 32'h0001_81C7);
    rd(8'h18, v); chk("R11 reads zero", v, 32'h0);

    // R7 deassert one cycle after clear
    @(negedge clk);
    chk("R7 irq high", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'hFFFF_FFFF);
    chk("R7 irq still high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R7 irq low", {31'b0, irq}, 32'h0);

    // R8 R9 state fields are live, ignore writes, raise nothing
    txs = 3'd7; rxs = 3'd7;
    wr(A_STS, 32'hFFFF_FE38);
    @(negedge clk);
    rd(A_STS, v); chk("R8 R9 state only", v, 32'h007E_0000);
    chk("R8 no irq", {31'b0, irq}, 32'h0);
    txs = 3'd5; rxs = 3'd2;
    rd(A_STS, v); chk("R8 live", v, 32'h0054_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule